// File: doc/BRIEF.md
# Linear Pixel Array Sequencer

This block is the digital control core of a linear light sensor with one row of pixels. A one-bit token is started by a serial start input and then moves one pixel along the row on each rising clock edge. A one-hot select vector comes from the token's position and routes one pixel at a time to the shared output stage. Each pixel's integrator gets a one-cycle reset pulse once the token has left it. An output-enable flag is high only while some pixel is selected. When it is low, the analog output stage must stay high-impedance.

A readout takes one clock edge per pixel plus one more edge, which clears the token from the last stage and returns the logic to idle. A start pulse that arrives while a token is still in the chain is dropped, and a sticky error flag records it. The analog parts are outside this block: photodiodes, integrators, amplifier and voltages. A binary pixel index output lets the downstream logic and the bench see which pixel is selected.

Top module: `lpa_sequencer`

## Requirements
- R1: A synchronous active-high reset clears `sel`, `int_rst`, `oe`, `pix_idx` and `proto_err` to zero. These values appear after the first clock edge with `rst` high.
- R2: If `si` is high on a rising edge while the chain is empty, the token loads into pixel 0. After that edge `sel` has bit 0 set and `oe` is 1.
- R3: On each rising edge the token moves from pixel i to pixel i+1. At most one bit of `sel` is ever high.
- R4: Number the edge on which `si` was accepted as edge 1. After edge 65, `sel` is all zero and `oe` is 0, so the 64th pixel is selected during exactly one cycle.
- R5: `oe` is 1 exactly when one bit of `sel` is 1.
- R6: Bit i of `int_rst` is high for exactly the one cycle after the edge on which `sel[i]` goes from 1 to 0. The same applies to pixel 63 on edge 65.
- R7: `pix_idx` gives the position of the high bit of `sel`, counted from 0 (pixel 0 gives 0, pixel 63 gives 63). It is 0 whenever `oe` is 0.
- R8: If `si` is high on an edge while a token is in the chain, including edge 65, it is ignored: `sel` moves exactly as if `si` were low. That edge also sets `proto_err` to 1, and only reset clears it.
- R9: A new start is accepted on edge 66 of the previous readout (the first edge with an empty chain). The bench applies it back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the token moves on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| si | input | 1 | Serial start pulse |
| sel | output | 64 | One-hot pixel select (bit i = pixel i) |
| int_rst | output | 64 | Per-pixel integrator reset pulse |
| oe | output | 1 | Output enable; 0 means the output stage is high-impedance |
| pix_idx | output | 6 | Index of the selected pixel |
| proto_err | output | 1 | Sticky flag for a start pulse that arrived too early |

## Verification
The assertions check on every cycle the relations between ports that must always hold:
- one-hot select;
- the enable matching the select;
- the index pointing at the selected bit;
- the one-step shift;
- the pulse on the last pixel;
- the error flag being sticky.

Only the bench's scenarios can show the exact edge counts of a readout:
- the 65th-edge release;
- a start refused at edge 65 and accepted at edge 66;
- a held start pulse;
- reset in the middle of a readout.

The bench also compares every output, each cycle, against a position-based reference model under random start pulses.

// File: rtl/lpa_pkg.sv
package lpa_pkg;

    localparam int unsigned LPA_NPIX = 64;
    localparam int unsigned LPA_IDXW = $clog2(LPA_NPIX);

    // Decision taken by the start logic on one edge
    typedef struct packed {
        logic accept;   // start loads a new token
        logic clash;    // start seen while busy: dropped
    } start_dec_t;

    function automatic start_dec_t decide_start(input logic si, input logic busy);
        start_dec_t d;
        d.accept = si & ~busy;
        d.clash  = si & busy;
        return d;
    endfunction

endpackage

// File: rtl/lpa_token_chain.sv
module lpa_token_chain #(
    parameter int unsigned NPIX = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    output logic [NPIX-1:0] sel_q,
    output logic [NPIX-1:0] sel_d,
    output logic [NPIX-1:0] irst_q
);

    assign sel_d[0] = load;

    genvar g;
    generate
        for (g = 1; g < NPIX; g++) begin : g_stage
            assign sel_d[g] = sel_q[g-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            irst_q <= '0;
        end else begin
            sel_q  <= sel_d;
            irst_q <= sel_q & ~sel_d;
        end
    end

endmodule

// File: rtl/lpa_index_encode.sv
module lpa_index_encode #(
    parameter int unsigned NPIX = 64,
    parameter int unsigned IDXW = $clog2(NPIX)
) (
    input  logic [NPIX-1:0] onehot,
    output logic [IDXW-1:0] idx
);

    // OR of the positions whose bit is set; valid because input is one-hot
    always_comb begin
        idx = '0;
        for (int i = 0; i < NPIX; i++) begin
            if (onehot[i]) idx = idx | IDXW'(i);
        end
    end

endmodule

// File: rtl/lpa_seq_ctrl.sv
module lpa_seq_ctrl
    import lpa_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic si,
    input  logic busy,
    input  logic busy_next,
    output logic load,
    output logic oe_q,
    output logic err_q
);

    start_dec_t dec;

    always_comb dec = decide_start(si, busy);

    assign load = dec.accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q  <= 1'b0;
            err_q <= 1'b0;
        end else begin
            oe_q  <= busy_next;
            err_q <= err_q | dec.clash;
        end
    end

endmodule

// File: rtl/lpa_sequencer.sv
module lpa_sequencer
    import lpa_pkg::*;
#(
    parameter int unsigned NPIX = LPA_NPIX,
    parameter int unsigned IDXW = $clog2(NPIX)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            si,
    output logic [NPIX-1:0] sel,
    output logic [NPIX-1:0] int_rst,
    output logic            oe,
    output logic [IDXW-1:0] pix_idx,
    output logic            proto_err
);

    logic [NPIX-1:0] sel_next;
    logic            load;

    lpa_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .si        (si),
        .busy      (|sel),
        .busy_next (|sel_next),
        .load      (load),
        .oe_q      (oe),
        .err_q     (proto_err)
    );

    lpa_token_chain #(.NPIX(NPIX)) u_chain (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .sel_q  (sel),
        .sel_d  (sel_next),
        .irst_q (int_rst)
    );

    lpa_index_encode #(.NPIX(NPIX), .IDXW(IDXW)) u_enc (
        .onehot (sel),
        .idx    (pix_idx)
    );

endmodule

// File: rtl/lpa_sequencer_chk.sv
module lpa_sequencer_chk #(
    parameter int unsigned NPIX = 64,
    parameter int unsigned IDXW = $clog2(NPIX)
) (
    input logic            clk,
    input logic            rst,
    input logic            si,
    input logic [NPIX-1:0] sel,
    input logic [NPIX-1:0] int_rst,
    input logic            oe,
    input logic [IDXW-1:0] pix_idx,
    input logic            proto_err
);

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sel == '0 && !oe && !proto_err && int_rst == '0)); // R1

    AST_START_LOAD: assert property (@(posedge clk) disable iff (rst)
        (si && !oe && !$past(rst)) |=> (sel[0] && oe)); // R2

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel)); // R3

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
        oe |=> (sel == ($past(sel) << 1))); // R3

    AST_LAST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        sel[NPIX-1] |=> (!oe && int_rst[NPIX-1])); // R4

    AST_OE_MATCH: assert property (@(posedge clk) disable iff (rst)
        oe == (sel != '0)); // R5

    AST_IRST_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(int_rst)); // R6

    AST_IDX_POINTS: assert property (@(posedge clk) disable iff (rst)
        oe |-> sel[pix_idx]); // R7

    AST_IDX_IDLE: assert property (@(posedge clk) disable iff (rst)
        !oe |-> (pix_idx == '0)); // R7

    AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
        (si && oe) |=> proto_err); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err); // R8

endmodule

bind lpa_sequencer lpa_sequencer_chk #(.NPIX(NPIX), .IDXW(IDXW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .si        (si),
    .sel       (sel),
    .int_rst   (int_rst),
    .oe        (oe),
    .pix_idx   (pix_idx),
    .proto_err (proto_err)
);

// File: tb/lpa_sequencer_test.sv
`timescale 1ns/1ps
module lpa_sequencer_test;

    localparam int NPIX = 64;
    localparam int IDXW = 6;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            si  = 1'b0;
    logic [NPIX-1:0] sel;
    logic [NPIX-1:0] int_rst;
    logic            oe;
    logic [IDXW-1:0] pix_idx;
    logic            proto_err;

    int n_checks = 0;
    int n_fail   = 0;

    // reference model state
    int pos  = -1;   // token position, -1 = empty
    int rpos = -1;   // pixel receiving integrator reset, -1 = none
    bit m_err = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    lpa_sequencer uut (
        .clk(clk), .rst(rst), .si(si), .sel(sel), .int_rst(int_rst),
        .oe(oe), .pix_idx(pix_idx), .proto_err(proto_err)
    );

    function automatic logic [NPIX-1:0] exp_vec(input int p);
        logic [NPIX-1:0] v = '0;
        if (p >= 0) v[p] = 1'b1;
        return v;
    endfunction

    function automatic logic [IDXW-1:0] exp_idx(input int p);
        return (p >= 0) ? IDXW'(p) : '0;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [NPIX-1:0] act, input logic [NPIX-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare(input string req);
        chk(sel == exp_vec(pos), req, "sel", sel, exp_vec(pos));
        chk(oe == (pos >= 0), "R5", "oe", NPIX'(oe), NPIX'(pos >= 0));
        chk(pix_idx == exp_idx(pos), "R7", "pix_idx", NPIX'(pix_idx), NPIX'(exp_idx(pos)));
        chk(int_rst == exp_vec(rpos), "R6", "int_rst", int_rst, exp_vec(rpos));
        chk(proto_err == m_err, "R8", "proto_err", NPIX'(proto_err), NPIX'(m_err));
    endtask

    // one clock: drive, update model at the edge, check mid-low phase
    task automatic step(input bit s, input bit r, input string req);
        si  = s;
        rst = r;
        @(posedge clk);
        if (r) begin
            pos = -1; rpos = -1; m_err = 1'b0;
        end else begin
            rpos = pos;
            if (pos >= 0) begin
                if (s) m_err = 1'b1;
                pos = (pos == NPIX-1) ? -1 : pos + 1;
            end else begin
                pos = s ? 0 : -1;
            end
        end
        @(negedge clk);
        compare(req);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R1: reset state
        step(1'b1, 1'b1, "R1");
        step(1'b0, 1'b1, "R1");
        step(1'b0, 1'b0, "R1");

        // R2/R3/R4: full readout, start edge = edge 1
        step(1'b1, 1'b0, "R2");
        for (int k = 2; k <= 64; k++) step(1'b0, 1'b0, "R3");
        chk(sel[NPIX-1] == 1'b1, "R4", "last pixel selected after edge 64",
            NPIX'(sel[NPIX-1]), NPIX'(1));
        step(1'b0, 1'b0, "R4");   // edge 65 releases
        chk(oe == 1'b0 && int_rst[NPIX-1], "R4", "released after edge 65",
            NPIX'(oe), NPIX'(0));

        // R9: back-to-back start on edge 66
        step(1'b1, 1'b0, "R9");
        chk(sel[0] && proto_err == 1'b0, "R9", "start on edge 66",
            sel, NPIX'(1));
        for (int k = 2; k <= 64; k++) step(1'b0, 1'b0, "R3");

        // R8: start on edge 65 is refused and flags error
        step(1'b1, 1'b0, "R8");
        chk(oe == 1'b0 && proto_err, "R8", "edge 65 start ignored",
            NPIX'({oe, proto_err}), NPIX'(2'b01));
        step(1'b0, 1'b0, "R8");   // error stays set while idle

        // R1: reset clears sticky error and a readout in progress
        step(1'b1, 1'b0, "R2");
        step(1'b1, 1'b0, "R8");   // held start: second edge is a clash
        for (int k = 0; k < 10; k++) step(1'b0, 1'b0, "R3");
        step(1'b0, 1'b1, "R1");
        chk(proto_err == 1'b0 && sel == '0, "R1", "mid-readout reset",
            sel, '0);
        step(1'b0, 1'b0, "R1");

        // random start pulses with mixed density
        for (int n = 0; n < 3000; n++) begin
            int thr = (n < 1500) ? 3 : 60;
            step(($urandom % 100) < thr, 1'b0, "R8");
            if (($urandom % 1000) == 0) step(1'b0, 1'b1, "R1");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule